// File: doc/BRIEF.md
# Two-Clock Frequency Ratio Monitor

The monitor decides whether a clock under test runs at the expected multiple of a trusted reference clock. Each clock drives its own down-counter. The reference counter runs first. When it reaches zero, a second reference-side counter opens an acceptance window. The measurement passes only if the test-clock counter runs out while that window is open. Any other ordering is a failure.

Software sets up the check through a small register port in the reference domain. It writes three seeds. The reference seed is the window length minus the allowed error. The window seed is twice the allowed error. The test seed is the window length times the expected ratio. Software then writes a control word made of 4-bit keys. A key enables its function only when it holds 0xA. The value 0x5, and any other value, leaves the function disabled.

The outcome appears in two sticky status bits, which software clears by writing one to them. Each bit can also drive an output pin, gated by its own key. After a measurement ends, the live counts can be read back. The ratio seen is then the test counts consumed divided by the sum of the reference seed and the window seed. Start, stop and expiry events cross between the clocks as toggles through two-flop synchronisers, so no request is lost.

Top module: `clk_ratio_mon`

## Requirements
- R1: After reset, the status word (word 1) reads 0, the control word (word 0) reads 0x5555, the test count (word 7) reads 0, and both `done_o` and `err_o` are low.
- R2: A measurement passes when the test counter expires after the reference counter (seeded from word 2) has run out and before the window counter (seeded from word 3) has run out. A pass sets the done bit, status bit 0.
- R3: If the test counter (seeded from word 4) expires while the reference counter is still running, the error bit (status bit 1) is set and the done bit stays clear.
- R4: If the window counter runs out before the test counter expires, the error bit is set and the test counter is halted.
- R5: `done_o` is high only while the done bit is set and the done-output key (control bits 15:12) equals 0xA. `err_o` follows the same rule with the error bit and the error-output key (control bits 11:8). Any other key value forces the output low. Each output follows its flag and key one reference cycle later.
- R6: Writing the control word with the run key (bits 3:0) equal to 0xA while the block is idle starts a measurement. Writing any other run key value stops a running measurement at once, and the stopped measurement sets no status bit. The busy bit is status bit 2.
- R7: With the single-shot key (bits 7:4) equal to 0xA, the block goes idle (busy bit 0) after one result.
- R8: With any other single-shot key value (continuous mode), a pass reloads all three counters and starts the next measurement at once. An error halts the block (busy bit 0) until software clears the error bit, and then the block restarts.
- R9: Writing 1 to status bit 0 or bit 1 clears that bit. Writing 0 to a bit leaves it unchanged.
- R10: Seeds are 20 bits wide and a test seed of 0xFFFFF is accepted and read back unchanged. The test count (word 7) never counts up during a measurement. Once the test counter has stopped, the count it held at the stop can be read back from word 7.
- R11: Every start request produces exactly one measurement, even when a start, a stop and a second start are written on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; also clocks the register port |
| rst_ref | input | 1 | Synchronous active-high reset, reference domain |
| clk_tst | input | 1 | Clock under test |
| rst_tst | input | 1 | Synchronous active-high reset, test domain |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word index |
| wdata | input | CW (20) | Write data |
| rdata | output | CW (20) | Registered read data for `addr` |
| done_o | output | 1 | Pass indication, gated by its key |
| err_o | output | 1 | Failure indication, gated by its key |

## Verification
The bench targets three failing orderings: a test clock that expires too early, one that expires too late, and a test seed of 0xFFFFF that must time out the window. A design that mixed up the two reference phases would report those as passes. The bench also writes a start, a stop and a second start on back-to-back cycles. A handshake that matched edges instead of levels would then stall, or would run a stale measurement. Finally, the bench checks that continuous mode stays halted while the error bit is set. It also checks that a stopped measurement never raises a flag later, which catches a stop that fails to reach the test domain.

// File: rtl/crm_pkg.sv
package crm_pkg;
  localparam logic [3:0] KEY_ON  = 4'hA;
  localparam logic [3:0] KEY_OFF = 4'h5;

  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_STAT   = 3'd1;
  localparam logic [2:0] A_SREF   = 3'd2;
  localparam logic [2:0] A_SVAL   = 3'd3;
  localparam logic [2:0] A_STST   = 3'd4;
  localparam logic [2:0] A_CREF   = 3'd5;
  localparam logic [2:0] A_CVAL   = 3'd6;
  localparam logic [2:0] A_CTST   = 3'd7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WACK,
    ST_REF,
    ST_VALID,
    ST_HALT
  } ctl_st_e;
endpackage

// File: rtl/crm_sync.sv
// Multi-stage synchroniser. Multi-bit use is only coherent for
// toggles, or for buses that are held stable while they are sampled.
module crm_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/crm_tst_side.sv
// Test-clock domain: the down-counter driven by the clock under test.
module crm_tst_side #(
  parameter int CW          = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_tst,
  input  logic          rst_tst,
  input  logic          start_tgl_a,
  input  logic          stop_tgl_a,
  input  logic [CW-1:0] seed_a,
  output logic          ack_tgl_o,
  output logic          exp_tgl_o,
  output logic [CW-1:0] cnt_o
);
  logic [1:0]    s_ctl;
  logic          start_d, stop_d, run_q, ack_q, exp_q;
  logic [CW-1:0] cnt_q;
  logic          start_ev, stop_ev;

  crm_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk_tst),
    .rst (rst_tst),
    .d_i ({start_tgl_a, stop_tgl_a}),
    .q_o (s_ctl)
  );

  assign start_ev = s_ctl[1] ^ start_d;
  assign stop_ev  = s_ctl[0] ^ stop_d;

  always_ff @(posedge clk_tst) begin
    if (rst_tst) begin
      start_d <= 1'b0;
      stop_d  <= 1'b0;
      run_q   <= 1'b0;
      ack_q   <= 1'b0;
      exp_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      start_d <= s_ctl[1];
      stop_d  <= s_ctl[0];
      if (start_ev) begin
        // The seed has been stable since before the toggle left the
        // reference domain.
        cnt_q <= seed_a;
        run_q <= 1'b1;
        ack_q <= s_ctl[1];
      end else if (stop_ev) begin
        run_q <= 1'b0;
      end else if (run_q) begin
        if (cnt_q == '0) begin
          run_q <= 1'b0;
          exp_q <= ~exp_q;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign ack_tgl_o = ack_q;
  assign exp_tgl_o = exp_q;
  assign cnt_o     = cnt_q;

  // R10: while a run continues, the test count only goes down
  assert_cnt_down_R10: assert property (@(posedge clk_tst) disable iff (rst_tst)
    (run_q && $past(run_q) && !$past(start_ev)) |-> (cnt_q < $past(cnt_q)));

  // R11: the counter runs only after a start request arrives
  assert_run_from_start_R11: assert property (@(posedge clk_tst) disable iff (rst_tst)
    $rose(run_q) |-> $past(start_ev));
endmodule

// File: rtl/crm_ref_ctrl.sv
// Reference domain sequencer: reference phase, then the acceptance window.
module crm_ref_ctrl
  import crm_pkg::*;
#(
  parameter int CW          = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] seed_ref,
  input  logic [CW-1:0] seed_valid,
  input  logic [CW-1:0] seed_tst,
  input  logic [3:0]    ss_key,
  input  logic          start_req,
  input  logic          stop_req,
  input  logic          err_flag_i,
  input  logic          ack_tgl_a,
  input  logic          exp_tgl_a,
  output logic          start_tgl_o,
  output logic          stop_tgl_o,
  output logic [CW-1:0] seed_hold_o,
  output logic          pass_p,
  output logic          fail_p,
  output logic          busy_o,
  output logic [CW-1:0] cnt_ref_o,
  output logic [CW-1:0] cnt_valid_o
);
  ctl_st_e       state_q;
  logic [1:0]    s_in;
  logic          exp_d, exp_ev, ack_ok, contin;
  logic          start_tgl_q, stop_tgl_q;
  logic [CW-1:0] cnt_ref_q, cnt_val_q, hold_q;

  crm_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({ack_tgl_a, exp_tgl_a}),
    .q_o (s_in)
  );

  assign exp_ev = s_in[0] ^ exp_d;
  // Comparing levels lets a stale acknowledge never match a newer start.
  assign ack_ok = (s_in[1] == start_tgl_q);
  assign contin = (ss_key != KEY_ON);

  always_comb begin
    pass_p = 1'b0;
    fail_p = 1'b0;
    if (!stop_req) begin
      case (state_q)
        ST_REF:   fail_p = exp_ev;
        ST_VALID: begin
          if (exp_ev)                 pass_p = 1'b1;
          else if (cnt_val_q == '0)   fail_p = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      exp_d       <= 1'b0;
      start_tgl_q <= 1'b0;
      stop_tgl_q  <= 1'b0;
      cnt_ref_q   <= '0;
      cnt_val_q   <= '0;
      hold_q      <= '0;
    end else begin
      exp_d <= s_in[0];
      if (stop_req && state_q != ST_IDLE) begin
        stop_tgl_q <= ~stop_tgl_q;
        state_q    <= ST_IDLE;
      end else begin
        case (state_q)
          ST_IDLE: if (start_req) begin
            start_tgl_q <= ~start_tgl_q;
            hold_q      <= seed_tst;
            state_q     <= ST_WACK;
          end
          ST_WACK: if (ack_ok) begin
            cnt_ref_q <= seed_ref;
            state_q   <= ST_REF;
          end
          ST_REF: begin
            if (fail_p) begin
              state_q <= contin ? ST_HALT : ST_IDLE;
            end else if (cnt_ref_q == '0) begin
              cnt_val_q <= seed_valid;
              state_q   <= ST_VALID;
            end else begin
              cnt_ref_q <= cnt_ref_q - 1'b1;
            end
          end
          ST_VALID: begin
            if (pass_p) begin
              if (contin) begin
                start_tgl_q <= ~start_tgl_q;
                hold_q      <= seed_tst;
                state_q     <= ST_WACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end else if (fail_p) begin
              stop_tgl_q <= ~stop_tgl_q;
              state_q    <= contin ? ST_HALT : ST_IDLE;
            end else begin
              cnt_val_q <= cnt_val_q - 1'b1;
            end
          end
          ST_HALT: if (!err_flag_i) begin
            start_tgl_q <= ~start_tgl_q;
            hold_q      <= seed_tst;
            state_q     <= ST_WACK;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign start_tgl_o = start_tgl_q;
  assign stop_tgl_o  = stop_tgl_q;
  assign seed_hold_o = hold_q;
  assign busy_o      = (state_q == ST_WACK) || (state_q == ST_REF) || (state_q == ST_VALID);
  assign cnt_ref_o   = cnt_ref_q;
  assign cnt_valid_o = cnt_val_q;

  // R2: the window opens only after the reference count is exhausted
  assert_valid_follows_ref_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_VALID && $past(state_q) == ST_REF) |-> ($past(cnt_ref_q) == '0));

  // R8: a halted continuous run stays halted while the error bit is set
  assert_halt_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HALT && err_flag_i && !stop_req) |=> (state_q == ST_HALT));

  // R7: single-shot mode goes idle after one result
  assert_single_stops_R7: assert property (@(posedge clk) disable iff (rst)
    ((pass_p || fail_p) && ss_key == KEY_ON) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/crm_regs.sv
// Register port, sticky status flags and key-gated outputs (reference domain).
module crm_regs
  import crm_pkg::*;
#(
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [CW-1:0] wdata,
  input  logic          pass_p,
  input  logic          fail_p,
  input  logic          busy_i,
  input  logic [CW-1:0] cnt_ref_i,
  input  logic [CW-1:0] cnt_valid_i,
  input  logic [CW-1:0] cnt_tst_i,
  output logic [CW-1:0] seed_ref_o,
  output logic [CW-1:0] seed_valid_o,
  output logic [CW-1:0] seed_tst_o,
  output logic [3:0]    ss_key_o,
  output logic          start_req_o,
  output logic          stop_req_o,
  output logic          err_flag_o,
  output logic          done_o,
  output logic          err_o,
  output logic [CW-1:0] rdata
);
  localparam int CTRL_W = 16;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CW-1:0]     sref_q, sval_q, stst_q;
  logic              done_q, err_q, wr_ctrl, wr_stat;
  logic [3:0]        done_key, err_key;

  assign wr_ctrl  = wr_en && (addr == A_CTRL);
  assign wr_stat  = wr_en && (addr == A_STAT);
  assign done_key = ctrl_q[15:12];
  assign err_key  = ctrl_q[11:8];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= {4{KEY_OFF}};
      sref_q <= '0;
      sval_q <= '0;
      stst_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
      rdata  <= '0;
    end else begin
      if (wr_ctrl)                    ctrl_q <= wdata[CTRL_W-1:0];
      if (wr_en && addr == A_SREF)    sref_q <= wdata;
      if (wr_en && addr == A_SVAL)    sval_q <= wdata;
      if (wr_en && addr == A_STST)    stst_q <= wdata;
      // A new event wins over a clear in the same cycle.
      done_q <= pass_p | (done_q & ~(wr_stat & wdata[0]));
      err_q  <= fail_p | (err_q  & ~(wr_stat & wdata[1]));
      done_o <= done_q && (done_key == KEY_ON);
      err_o  <= err_q  && (err_key  == KEY_ON);
      case (addr)
        A_CTRL:  rdata <= {{(CW-CTRL_W){1'b0}}, ctrl_q};
        A_STAT:  rdata <= {{(CW-3){1'b0}}, busy_i, err_q, done_q};
        A_SREF:  rdata <= sref_q;
        A_SVAL:  rdata <= sval_q;
        A_STST:  rdata <= stst_q;
        A_CREF:  rdata <= cnt_ref_i;
        A_CVAL:  rdata <= cnt_valid_i;
        default: rdata <= cnt_tst_i;
      endcase
    end
  end

  assign seed_ref_o   = sref_q;
  assign seed_valid_o = sval_q;
  assign seed_tst_o   = stst_q;
  assign ss_key_o     = ctrl_q[7:4];
  assign start_req_o  = wr_ctrl && (wdata[3:0] == KEY_ON);
  assign stop_req_o   = wr_ctrl && (wdata[3:0] != KEY_ON);
  assign err_flag_o   = err_q;

  // R9: a write of one clears the done bit unless a pass arrives at once
  assert_w1c_done_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && wdata[0] && !pass_p) |=> !done_q);

  // R5: the done output needs its key at 0xA
  assert_out_gate_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(done_key) == KEY_ON));
endmodule

// File: rtl/clk_ratio_mon.sv
module clk_ratio_mon #(
  parameter int CW          = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_ref,
  input  logic          rst_ref,
  input  logic          clk_tst,
  input  logic          rst_tst,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic          done_o,
  output logic          err_o
);
  logic [CW-1:0] seed_ref, seed_valid, seed_tst, seed_hold;
  logic [CW-1:0] cnt_ref, cnt_valid, cnt_tst, cnt_tst_s;
  logic [3:0]    ss_key;
  logic          start_req, stop_req, err_flag, pass_p, fail_p, busy;
  logic          start_tgl, stop_tgl, ack_tgl, exp_tgl;

  crm_regs #(.CW(CW)) u_regs (
    .clk          (clk_ref),
    .rst          (rst_ref),
    .wr_en        (wr_en),
    .addr         (addr),
    .wdata        (wdata),
    .pass_p       (pass_p),
    .fail_p       (fail_p),
    .busy_i       (busy),
    .cnt_ref_i    (cnt_ref),
    .cnt_valid_i  (cnt_valid),
    .cnt_tst_i    (cnt_tst_s),
    .seed_ref_o   (seed_ref),
    .seed_valid_o (seed_valid),
    .seed_tst_o   (seed_tst),
    .ss_key_o     (ss_key),
    .start_req_o  (start_req),
    .stop_req_o   (stop_req),
    .err_flag_o   (err_flag),
    .done_o       (done_o),
    .err_o        (err_o),
    .rdata        (rdata)
  );

  crm_ref_ctrl #(.CW(CW), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk         (clk_ref),
    .rst         (rst_ref),
    .seed_ref    (seed_ref),
    .seed_valid  (seed_valid),
    .seed_tst    (seed_tst),
    .ss_key      (ss_key),
    .start_req   (start_req),
    .stop_req    (stop_req),
    .err_flag_i  (err_flag),
    .ack_tgl_a   (ack_tgl),
    .exp_tgl_a   (exp_tgl),
    .start_tgl_o (start_tgl),
    .stop_tgl_o  (stop_tgl),
    .seed_hold_o (seed_hold),
    .pass_p      (pass_p),
    .fail_p      (fail_p),
    .busy_o      (busy),
    .cnt_ref_o   (cnt_ref),
    .cnt_valid_o (cnt_valid)
  );

  crm_tst_side #(.CW(CW), .SYNC_STAGES(SYNC_STAGES)) u_tst (
    .clk_tst     (clk_tst),
    .rst_tst     (rst_tst),
    .start_tgl_a (start_tgl),
    .stop_tgl_a  (stop_tgl),
    .seed_a      (seed_hold),
    .ack_tgl_o   (ack_tgl),
    .exp_tgl_o   (exp_tgl),
    .cnt_o       (cnt_tst)
  );

  // The test count reads coherently once the counter has stopped.
  crm_sync #(.W(CW), .STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk (clk_ref),
    .rst (rst_ref),
    .d_i (cnt_tst),
    .q_o (cnt_tst_s)
  );
endmodule

// File: tb/clk_ratio_mon_tb.sv
`timescale 1ns/1ps
module clk_ratio_mon_tb;
  localparam int CW = 20;

  logic clk_ref = 1'b0, clk_tst = 1'b0, rst = 1'b1;
  real  tst_half = 1.25;
  always #2.5 clk_ref = ~clk_ref;
  always #(tst_half) clk_tst = ~clk_tst;

  logic          wr_en = 1'b0;
  logic [2:0]    addr  = '0;
  logic [CW-1:0] wdata = '0;
  logic [CW-1:0] rdata;
  logic          done_o, err_o;

  int   vecs = 0, miss = 0;
  bit   quiet = 0, ended = 0, m_done = 0, m_err = 0;
  logic [3:0] m_kd = 4'h5, m_ke = 4'h5;

  clk_ratio_mon #(.CW(CW)) u_dut (
    .clk_ref (clk_ref), .rst_ref (rst), .clk_tst (clk_tst), .rst_tst (rst),
    .wr_en (wr_en), .addr (addr), .wdata (wdata), .rdata (rdata),
    .done_o (done_o), .err_o (err_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-cycle comparison of the outputs against the model's flags (R5)
  always @(negedge clk_ref) begin
    if (quiet && !ended) begin
      chk(done_o == (m_done && m_kd == 4'hA), "R5 done_o", done_o, m_done && m_kd == 4'hA);
      chk(err_o  == (m_err  && m_ke == 4'hA), "R5 err_o",  err_o,  m_err && m_ke == 4'hA);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
    @(negedge clk_ref); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk_ref); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [CW-1:0] d);
    @(negedge clk_ref); addr = a;
    @(negedge clk_ref); d = rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk_ref);
    quiet = 1;
  endtask

  task automatic seeds(input int s0, input int sv, input int s1);
    wr(3'd2, CW'(s0)); wr(3'd3, CW'(sv)); wr(3'd4, CW'(s1));
  endtask

  task automatic wait_result(output logic [CW-1:0] st);
    bit got = 0;
    for (int i = 0; i < 4000 && !got; i++) begin
      rd(3'd1, st);
      if (st[1:0] != 2'b00) got = 1;
    end
    if (!got) chk(0, "R11 measurement finished", st, 0);
  endtask

  // Model: the expiry, seen in reference cycles after synchronisation,
  // must land inside the acceptance window.
  function automatic bit pred_pass(input int s0, input int sv, input int s1);
    real x;
    x = (s1 + 1) * 2.0 * tst_half / 5.0 + 3.0;
    return (x > s0 + 4.0) && (x < s0 + sv + 5.0);
  endfunction

  task automatic finish_up();
    ended = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_ref);
    if (!ended) begin
      vecs++; miss++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_up();
    end
  end

  initial begin
    logic [CW-1:0] st, v;
    bit pp;
    repeat (6) @(negedge clk_ref);
    rst = 1'b0;
    repeat (2) @(negedge clk_ref);

    // R1 reset state
    rd(3'd1, st); chk(st == 0, "R1 status", st, 0);
    rd(3'd0, v);  chk(v == 20'h5555, "R1 control", v, 20'h5555);
    rd(3'd7, v);  chk(v == 0, "R1 test count", v, 0);
    chk(!done_o && !err_o, "R1 outputs", {done_o, err_o}, 0);
    settle();

    // R2 single-shot pass, ratio 2
    quiet = 0;
    seeds(90, 20, 200); pp = pred_pass(90, 20, 200);
    wr(3'd0, 20'hAAAA);
    wait_result(st);
    chk(st[1:0] == (pp ? 2'b01 : 2'b10), "R2 pass at ratio 2", st, pp ? 1 : 2);
    repeat (3) @(negedge clk_ref);
    rd(3'd1, st); chk(st[2] == 0, "R7 idle after single shot", st, 1);
    m_done = 1; m_kd = 4'hA; m_ke = 4'hA; settle();

    // R9 write-one-to-clear
    quiet = 0;
    wr(3'd1, 20'h0); rd(3'd1, st); chk(st[0] == 1, "R9 write zero keeps done", st, 1);
    wr(3'd1, 20'h1); rd(3'd1, st); chk(st == 0, "R9 write one clears done", st, 0);
    m_done = 0; settle();

    // R3 early expiry
    quiet = 0;
    seeds(90, 20, 100); pp = pred_pass(90, 20, 100);
    wr(3'd0, 20'hAAAA);
    wait_result(st);
    chk(st[1:0] == (pp ? 2'b01 : 2'b10), "R3 early expiry is error", st, pp ? 1 : 2);
    m_err = 1; settle();
    repeat (4) @(negedge clk_ref);
    chk(err_o == 1, "R5 err_o with key A", err_o, 1);
    quiet = 0; wr(3'd1, 20'h2); m_err = 0; settle();

    // R4 / R10 window runs out with a full-width seed
    quiet = 0;
    seeds(90, 20, 20'hFFFFF);
    rd(3'd4, v); chk(v == 20'hFFFFF, "R10 seed 0xFFFFF accepted", v, 20'hFFFFF);
    wr(3'd0, 20'hAAAA);
    wait_result(st);
    chk(st[1:0] == 2'b10, "R4 window timeout is error", st, 2);
    repeat (10) @(negedge clk_ref);
    rd(3'd7, v);
    chk((20'hFFFFF - v) >= 200 && (20'hFFFFF - v) <= 300, "R10 consumed test counts", 20'hFFFFF - v, 233);
    begin
      real ratio;
      ratio = real'(20'hFFFFF - v) / 110.0;
      chk(ratio > 1.8 && ratio < 2.7, "R10 measured ratio near 2", int'(ratio * 100), 200);
    end
    m_err = 1; settle();
    quiet = 0; wr(3'd1, 20'h2); m_err = 0; settle();

    // R5 key gating of done_o
    quiet = 0;
    seeds(90, 20, 200);
    wr(3'd0, 20'h5AAA);
    wait_result(st);
    m_done = 1; m_kd = 4'h5; settle();
    repeat (3) @(negedge clk_ref);
    chk(done_o == 0, "R5 done_o off with key 5", done_o, 0);
    quiet = 0; wr(3'd0, 20'h3AA5); m_kd = 4'h3; settle();
    chk(done_o == 0, "R5 done_o off with key 3", done_o, 0);
    quiet = 0; wr(3'd0, 20'hAAA5); m_kd = 4'hA; settle();
    chk(done_o == 1, "R5 done_o on with key A", done_o, 1);
    quiet = 0; wr(3'd1, 20'h3); m_done = 0; settle();

    // R8 continuous mode keeps measuring after a pass
    quiet = 0;
    seeds(90, 20, 200);
    wr(3'd0, 20'hAA5A);
    wait_result(st);
    chk(st[1:0] == 2'b01, "R8 continuous first pass", st, 1);
    repeat (20) @(negedge clk_ref);
    rd(3'd1, st); chk(st[2] == 1, "R8 continuous restarted", st, 4);
    wr(3'd1, 20'h1);
    wait_result(st);
    chk(st[1:0] == 2'b01, "R8 reloaded pass", st, 1);
    wr(3'd0, 20'hAA55);
    rd(3'd1, st); chk(st[2] == 0, "R6 stop clears busy", st, 0);
    wr(3'd1, 20'h3);
    repeat (400) @(negedge clk_ref);
    rd(3'd1, st); chk(st == 0, "R6 no flag after stop", st, 0);

    // R8 continuous halt on error, restart after clear
    seeds(90, 20, 100);
    wr(3'd0, 20'hAA5A);
    wait_result(st);
    chk(st[1:0] == 2'b10, "R8 continuous error", st, 2);
    repeat (60) @(negedge clk_ref);
    rd(3'd1, st); chk(st == 3'b010, "R8 halted while error set", st, 2);
    wr(3'd4, 20'd200);
    wr(3'd1, 20'h2);
    wait_result(st);
    chk(st[1:0] == 2'b01, "R8 restart after clear passes", st, 1);
    wr(3'd0, 20'hAA55);
    wr(3'd1, 20'h3);

    // Ratio 1 patterns
    tst_half = 2.5;
    repeat (20) @(negedge clk_ref);
    seeds(90, 20, 100); pp = pred_pass(90, 20, 100);
    wr(3'd0, 20'hAAAA);
    wait_result(st);
    chk(st[1:0] == (pp ? 2'b01 : 2'b10), "R2 pass at ratio 1", st, pp ? 1 : 2);
    wr(3'd1, 20'h3);
    seeds(90, 20, 40); pp = pred_pass(90, 20, 40);
    wr(3'd0, 20'hAAAA);
    wait_result(st);
    chk(st[1:0] == (pp ? 2'b01 : 2'b10), "R3 early at ratio 1", st, pp ? 1 : 2);
    wr(3'd1, 20'h3);

    // R6 stop in the middle of a long measurement
    seeds(1000, 20, 2050);
    wr(3'd0, 20'hAAAA);
    repeat (50) @(negedge clk_ref);
    rd(3'd1, st); chk(st[2] == 1, "R6 run key A starts", st, 4);
    wr(3'd0, 20'hAAA5);
    repeat (3000) @(negedge clk_ref);
    rd(3'd1, st); chk(st == 0, "R6 stopped run sets nothing", st, 0);

    // R11 start, stop, start on consecutive cycles
    seeds(90, 20, 100);
    @(negedge clk_ref); wr_en = 1'b1; addr = 3'd0; wdata = 20'hAAAA;
    @(negedge clk_ref); wdata = 20'hAAA5;
    @(negedge clk_ref); wdata = 20'hAAAA;
    @(negedge clk_ref); wr_en = 1'b0;
    wait_result(st);
    chk(st[1:0] == 2'b01, "R11 back-to-back start measures", st, 1);
    wr(3'd1, 20'h1);
    repeat (300) @(negedge clk_ref);
    rd(3'd1, st); chk(st == 0, "R11 only one measurement", st, 0);

    finish_up();
  end
endmodule